// File: doc/BRIEF.md
# Grouped External Interrupt Controller

This block collects external interrupt sources into seven 32-bit groups and condenses each group into one request line for a downstream vectored interrupt controller. It has 128 general-purpose pin inputs and two on-chip event inputs. A timer end-count match and a USB cable plug event share the lowest group. Pins land in groups 6 down to 3 through a fixed mapping that uses each group's four 8-bit lanes in reverse order. The request lines are also wired in reverse, so group g drives request line 6 − g.

Every source has four control bits, one in each of four register banks:

- **Polarity:** 1 means active high or rising edge, 0 means active low or falling edge.
- **Sense:** 0 means edge, 1 means level.
- **Enable.**
- **Status.**

Raw inputs are resynchronised by two flops before detection. Software uses a simple 32-bit register port to configure sources, poll status and acknowledge edge events. Several bit positions are unused and are hard-wired off.

Top module: `eint_group_ctrl`

## Requirements
- R1: After reset, every register reads 0 and all request lines are low.
- R2: Register addresses use byte offset 0x80 + 4g for polarity, 0xA0 + 4g for status, 0xC0 + 4g for enable and 0xE0 + 4g for sense, with g from 0 to 6. Polarity and sense read back what was written. Any other address reads 0.
- R3: Pin n (0 to 127) is source bit ((24 − (n & 24)) | (n & 7)) of group 6 − (n >> 5).
- R4: Group g asserts request output `eint_req[6 − g]`.
- R5: With sense 0, a status bit sets on the active edge: rising when polarity is 1, falling when polarity is 0. It stays set after the input returns to idle, and it clears when 1 is written to that bit of the status register.
- R6: With sense 1, a status bit is 1 exactly while the synchronised input is at the active level.
- R7: Some positions are disabled. These are every bit of groups 1 and 2, bits 7:4 of group 3 (pins 124 to 127), and every bit of group 0 except bits 0 and 2. At disabled positions, enable writes are dropped, enable reads back 0 and status never sets.
- R8: Group 0 bit 0 is driven by `timer_match` and group 0 bit 2 is driven by `usb_cable`.
- R9: A change at an input is visible in status after the third rising clock edge and not after the second.
- R10: A request line is the OR of status AND enable over its group. With enable cleared, a pending status raises no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| gpio_in | input | 128 | Raw pin inputs |
| timer_match | input | 1 | Raw timer end-count event |
| usb_cable | input | 1 | Raw USB cable plug event |
| eint_req | output | 7 | Request lines, one per group, in reverse group order |

## Verification
The bench drives pins taken from every lane and every mapped group. A design with the wrong lane reversal, or with groups in forward order, would raise the status and request of the wrong bit or line. Each pin is checked one cycle before and exactly at the edge where status should first show the event, so a one-flop or three-flop synchroniser is caught. The bench checks that edge events persist after the input returns to idle and that level events drop when it does; mixing up the sense encoding, or ignoring write-one-to-clear, shows up there. Disabled positions and the two group 0 events are probed separately, because a design with a wrong mask would read back enable bits that should be zero, or would raise requests from pins 124 to 127.

// File: rtl/eint_group_ctrl.sv
module eint_group_ctrl #(
  parameter int NGRP  = 7,
  parameter int GW    = 32,
  parameter int NGPIO = 128,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic [GW-1:0]    bus_wdata,
  output logic [GW-1:0]    bus_rdata,
  input  logic [NGPIO-1:0] gpio_in,
  input  logic             timer_match,
  input  logic             usb_cable,
  output logic [NGRP-1:0]  eint_req
);
  localparam int NB = NGRP * GW;

  function automatic logic [GW-1:0] usable(input int g);
    case (g)
      0:       return GW'(32'h0000_0005);
      1, 2:    return '0;
      3:       return ~GW'(32'h0000_00F0);
      default: return '1;
    endcase
  endfunction

  logic [NB-1:0] raw, s1, s2, s2_d;
  logic [NB-1:0] lv_f, st_f, en_f, ty_f;

  always_comb begin
    raw = '0;
    for (int n = 0; n < NGPIO; n++) begin
      raw[(NGRP - 1 - (n >> 5)) * GW + ((24 - (n & 24)) | (n & 7))] = gpio_in[n];
    end
    raw[0] = timer_match;
    raw[2] = usb_cable;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1   <= '0;
      s2   <= '0;
      s2_d <= '0;
    end else begin
      s1   <= raw;
      s2   <= s1;
      s2_d <= s2;
    end
  end

  logic [2:0] kind, grp;
  logic       hit;
  assign kind = bus_addr[7:5];
  assign grp  = bus_addr[4:2];
  assign hit  = bus_addr[7] && (int'(grp) < NGRP) && (bus_addr[1:0] == 2'b00);

  for (genvar g = 0; g < NGRP; g++) begin : gen_grp
    localparam logic [GW-1:0] MASK = usable(g);
    logic [GW-1:0] lv_q, st_q, en_q, ty_q;
    logic [GW-1:0] act, act_d, rise, clr;
    logic          sel;

    assign sel   = bus_wr && hit && (int'(grp) == g);
    assign act   = ~(s2[g*GW +: GW] ^ lv_q);
    assign act_d = ~(s2_d[g*GW +: GW] ^ lv_q);
    assign rise  = act & ~act_d;
    assign clr   = (sel && kind == 3'b101) ? bus_wdata : '0;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lv_q <= '0;
        st_q <= '0;
        en_q <= '0;
        ty_q <= '0;
      end else begin
        if (sel && kind == 3'b100) lv_q <= bus_wdata;
        if (sel && kind == 3'b110) en_q <= bus_wdata & MASK;
        if (sel && kind == 3'b111) ty_q <= bus_wdata;
        st_q <= MASK & ((ty_q & act) | (~ty_q & ((st_q & ~clr) | rise)));
      end
    end

    assign lv_f[g*GW +: GW] = lv_q;
    assign st_f[g*GW +: GW] = st_q;
    assign en_f[g*GW +: GW] = en_q;
    assign ty_f[g*GW +: GW] = ty_q;
    assign eint_req[NGRP-1-g] = |(st_q & en_q);
  end

  always_comb begin
    bus_rdata = '0;
    if (hit) begin
      case (kind)
        3'b100:  bus_rdata = lv_f[int'(grp)*GW +: GW];
        3'b101:  bus_rdata = st_f[int'(grp)*GW +: GW];
        3'b110:  bus_rdata = en_f[int'(grp)*GW +: GW];
        3'b111:  bus_rdata = ty_f[int'(grp)*GW +: GW];
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/eint_group_chk.sv
module eint_group_chk #(
  parameter int NGRP = 7,
  parameter int GW   = 32,
  parameter int AW   = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [AW-1:0]        bus_addr,
  input logic                 bus_wr,
  input logic [GW-1:0]        bus_wdata,
  input logic [NGRP-1:0]      eint_req,
  input logic [NGRP*GW-1:0]   st_f,
  input logic [NGRP*GW-1:0]   en_f,
  input logic [NGRP*GW-1:0]   ty_f
);
  assert_reset_quiet_R1: assert property (@(posedge clk) $rose(rst_n) |-> eint_req == '0);

  for (genvar g = 0; g < NGRP; g++) begin : gen_chk
    localparam logic [GW-1:0] OFF = (g == 0) ? ~GW'(32'h5) :
                                    (g == 1 || g == 2) ? '1 :
                                    (g == 3) ? GW'(32'hF0) : '0;
    localparam logic [AW-1:0] A_ST = AW'(8'hA0 + 4 * g);
    localparam logic [AW-1:0] A_EN = AW'(8'hC0 + 4 * g);

    assert_dis_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_f[g*GW +: GW] | en_f[g*GW +: GW]) & OFF) == '0);

    assert_en_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_EN && bus_wdata == '0) |=> !eint_req[NGRP-1-g]);

    assert_edge_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == A_ST) |=>
      (($past(st_f[g*GW +: GW]) & ~$past(ty_f[g*GW +: GW]) & ~ty_f[g*GW +: GW]
        & ~st_f[g*GW +: GW]) == '0));
  end
endmodule

bind eint_group_ctrl eint_group_chk #(.NGRP(NGRP), .GW(GW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .eint_req(eint_req),
  .st_f(st_f), .en_f(en_f), .ty_f(ty_f)
);

// File: tb/test_eint_group_ctrl.sv
module test_eint_group_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [127:0] gpio_in = '0;
  logic        timer_match = 0;
  logic        usb_cable = 0;
  logic [6:0]  eint_req;

  int nchk = 0, nerr = 0;
  bit done = 0;

  always #5 clk = ~clk;

  eint_group_ctrl i_eint_group_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gpio_in(gpio_in),
    .timer_match(timer_match), .usb_cable(usb_cable), .eint_req(eint_req)
  );

  // pin[9:2], sense[1], polarity[0]
  localparam logic [9:0] VEC [8] = '{
    {8'd0,   1'b0, 1'b1}, {8'd37,  1'b0, 1'b0}, {8'd70,  1'b1, 1'b1},
    {8'd101, 1'b1, 1'b0}, {8'd123, 1'b0, 1'b1}, {8'd15,  1'b1, 1'b1},
    {8'd90,  1'b0, 1'b0}, {8'd56,  1'b0, 1'b1}
  };

  function automatic int grp_of(input int n); return 6 - (n >> 5); endfunction
  function automatic int bit_of(input int n); return (24 - (n & 24)) | (n & 7); endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic settle(); repeat (4) @(negedge clk); endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    for (int g = 0; g < 7; g++) begin
      rd(8'h80 + 8'(4*g), d); check("R1 polarity", d, 0);
      rd(8'hA0 + 8'(4*g), d); check("R1 status", d, 0);
      rd(8'hC0 + 8'(4*g), d); check("R1 enable", d, 0);
      rd(8'hE0 + 8'(4*g), d); check("R1 sense", d, 0);
    end
    check("R1 requests", {25'd0, eint_req}, 0);

    for (int i = 0; i < 8; i++) begin
      int n, g, b;
      logic t, l;
      n = int'(VEC[i][9:2]); t = VEC[i][1]; l = VEC[i][0];
      g = grp_of(n); b = bit_of(n);
      gpio_in[n] = ~l;
      wr(8'h80 + 8'(4*g), 32'(l) << b);
      wr(8'hE0 + 8'(4*g), 32'(t) << b);
      settle();
      wr(8'hA0 + 8'(4*g), '1);
      settle();
      rd(8'hA0 + 8'(4*g), d); check("R3 idle status", d, 0);
      @(negedge clk); gpio_in[n] = l;
      @(posedge clk); @(posedge clk);
      @(negedge clk); #1 check("R9 not after second edge", st_probe(g), 0);
      @(negedge clk); #1 check("R3 mapped bit after third edge", st_probe(g), 32'(1) << b);
      check("R10 no request while disabled", {25'd0, eint_req}, 0);
      wr(8'hC0 + 8'(4*g), 32'(1) << b);
      #1 check("R4 request line", {25'd0, eint_req}, 32'(1) << (6 - g));
      @(negedge clk); gpio_in[n] = ~l;
      settle();
      rd(8'hA0 + 8'(4*g), d);
      if (t) check("R6 level drops", d, 0);
      else   check("R5 edge holds", d, 32'(1) << b);
      wr(8'hA0 + 8'(4*g), 32'(1) << b);
      #1 rd(8'hA0 + 8'(4*g), d); check("R5 cleared by write one", d, 0);
      check("R4 request gone", {25'd0, eint_req}, 0);
      gpio_in[n] = 0;
      wr(8'hC0 + 8'(4*g), 0);
      wr(8'h80 + 8'(4*g), 0);
      wr(8'hE0 + 8'(4*g), 0);
      settle();
      wr(8'hA0 + 8'(4*g), '1);
      settle();
    end

    // R2 readback and unmapped
    wr(8'h84, 32'hA5A5_0000); rd(8'h84, d); check("R2 polarity readback", d, 32'hA5A5_0000);
    wr(8'hF8, 32'h0000_1234); rd(8'hF8, d); check("R2 sense readback", d, 32'h0000_1234);
    rd(8'h9C, d); check("R2 unmapped group 7", d, 0);
    rd(8'h04, d); check("R2 low address", d, 0);
    wr(8'h84, 0); wr(8'hF8, 0);

    // R7 disabled positions
    wr(8'hC4, '1); rd(8'hC4, d); check("R7 group 1 enable", d, 0);
    wr(8'hC8, '1); rd(8'hC8, d); check("R7 group 2 enable", d, 0);
    wr(8'hCC, '1); rd(8'hCC, d); check("R7 group 3 enable", d, 32'hFFFF_FF0F);
    wr(8'hC0, '1); rd(8'hC0, d); check("R7 group 0 enable", d, 32'h5);
    wr(8'h8C, '1);
    settle(); wr(8'hAC, '1); settle();
    @(negedge clk); gpio_in[127:124] = 4'hF;
    settle();
    rd(8'hAC, d); check("R7 pins 124-127 status", d, 0);
    check("R7 no request", {25'd0, eint_req}, 0);
    gpio_in[127:124] = 0; wr(8'hCC, 0); wr(8'h8C, 0); settle(); wr(8'hAC, '1);

    // R8 group 0 events
    wr(8'h80, '1); settle(); wr(8'hA0, '1); settle();
    @(negedge clk); timer_match = 1;
    settle();
    rd(8'hA0, d); check("R8 timer bit", d, 32'h1);
    check("R8 timer request", {25'd0, eint_req}, 32'h40);
    @(negedge clk); usb_cable = 1;
    settle();
    rd(8'hA0, d); check("R8 usb bit", d, 32'h5);
    wr(8'hA0, 32'h1); rd(8'hA0, d); check("R5 selective clear", d, 32'h4);
    check("R10 request held by usb", {25'd0, eint_req}, 32'h40);
    wr(8'hC0, 0);
    #1 check("R10 enable cleared", {25'd0, eint_req}, 0);

    finish_run();
  end

  function automatic logic [31:0] st_probe(input int g);
    // status is read through the bus address held on the port
    return (bus_addr == 8'hA0 + 8'(4*g)) ? bus_rdata : 32'hDEAD_BEEF;
  endfunction

  always @(negedge clk) if (rst_n && !bus_wr && bus_addr[7:5] != 3'b101) ;
endmodule